// File: doc/BRIEF.md
# Watchdog Timer with Selectable Prescaler

This block guards a chip against a hung program. A 16-bit up-counter advances once per prescaler tick. The prescaler divides the peripheral clock by a power of two that software selects. Software has to keep writing a clear register so that the counter never passes its all-ones value. If the counter does wrap to zero, the block takes one of two actions. In reset mode it drives a fixed-length, chip-wide reset pulse. In the other mode it keeps counting from zero and, if enabled, raises a one-cycle interrupt.

The block sits on a simple register bus made of a byte address, write data, a write strobe and combinational read data. There are two registers. The configuration register holds the enable, the mode, the interrupt enable and the prescaler select. The clear register responds to any write and has no storage. While the watchdog is disabled, its counter rests at 0xFFE0. Software that enables it without a clear therefore gets a wrap 32 ticks later.

Top module: `wdog_timer`

## Requirements
- R1: The configuration register is at byte address 0x80000270. Its fields are: enable at bit 0, reset-mode at bit 1, interrupt-enable at bit 3, and a 3-bit prescaler select at bits [6:4]. It reads back what was written to those fields. Bit 2 and bits [15:7] always read zero. Reads of the clear register (0x80000274) or of any other address return zero.
- R2: For a select value s from 0 to 4, a tick occurs every 2^(s+1) clocks. For s = 5 a tick occurs every 1024 clocks, and for s = 6 every 4096 clocks. The value 7 behaves like 6, and `sel_bad_o` is high exactly while the stored select is 7.
- R3: While enable is 0, the counter is held at 0xFFE0. Once the block is enabled with no clear, the 32nd tick wraps the counter to zero.
- R4: A write of any data to 0x80000274 sets the counter to zero. If that write and a tick fall in the same cycle, the clear wins and no wrap occurs.
- R5: A wrap while reset-mode is 1 drives `chip_rst_o` high for exactly 16 clocks, starting the clock after the wrapping tick. No interrupt is raised in that case.
- R6: At the clock where the reset pulse ends, the configuration register returns to all zeros, which disables the watchdog.
- R7: A wrap while reset-mode is 0 produces no reset, and the counter continues from zero. If interrupt-enable is 1, `irq_o` is high for one clock, the clock after the wrapping tick. If interrupt-enable is 0, nothing is raised.
- R8: Every write to the configuration register restarts the prescaler from zero, and the prescaler also stays at zero while the block is disabled. After the write that enables the block with divide N, the first tick comes N clocks later.
- R9: When `rst_n` is low at a clock edge, the block resets synchronously. The configuration becomes all zeros and `chip_rst_o` and `irq_o` go low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe, one access per high cycle |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| chip_rst_o | output | 1 | Chip-wide reset pulse, active high |
| irq_o | output | 1 | One-cycle wrap interrupt |
| sel_bad_o | output | 1 | Stored prescaler select holds the undefined value 7 |

## Verification
The hardest event to reach from the ports is a wrap. Starting from zero, a wrap takes 65536 ticks, and at the slower divides that means millions of clocks. The stimulus avoids this by enabling the block without a clear, so the 0xFFE0 preload leaves only 32 ticks before the wrap. The block is disabled again before each scenario to restore the preload. Clears are also placed at varying phases against a divide-by-two prescaler so that some of them collide with a tick. Repeated configuration writes then shift the wrap by a computable number of clocks, which exposes the prescaler restart.

// File: rtl/wdog_pkg.sv
// Shared definitions for the watchdog.
// Holds the configuration register layout, the stored configuration type and
// the prescaler exponent for each select value.
// Assumes a 3-bit select field. The exponent mapping is fixed by the spec.
package wdog_pkg;

    localparam int unsigned BIT_ENA  = 0;
    localparam int unsigned BIT_RSTM = 1;
    localparam int unsigned BIT_IEN  = 3;
    localparam int unsigned SEL_LSB  = 4;
    localparam int unsigned SEL_W    = 3;
    localparam int unsigned N_SEL    = 1 << SEL_W;

    typedef struct packed {
        logic [SEL_W-1:0] div_sel;
        logic             irq_en;
        logic             rst_mode;
        logic             ena;
    } wdog_cfg_t;

    // Power-of-two exponent of the divide for one select value.
    function automatic int unsigned div_exp(input logic [SEL_W-1:0] sel);
        if (sel < 3'd5)
            return {29'd0, sel} + 32'd1;
        else if (sel == 3'd5)
            return 32'd10;
        else
            return 32'd12;
    endfunction

    localparam int unsigned PRE_W = div_exp(3'd6);

endpackage

// File: rtl/wdog_regs.sv
// Register decode and configuration storage.
// A write to CFG_ADDR loads the defined fields; a write to CLR_ADDR only
// produces a strobe. Read data is combinational. A wipe pulse, raised when
// the reset pulse ends, zeroes the configuration and takes priority over a
// write in the same cycle.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 16,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 32'h8000_0270,
    parameter logic [ADDR_W-1:0] CLR_ADDR = 32'h8000_0274
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              wipe,
    output wdog_cfg_t         cfg_q,
    output logic              cfg_wr,
    output logic              clr_wr,
    output logic [DATA_W-1:0] rdata,
    output logic              sel_bad
);

    logic hit_cfg;
    logic hit_clr;
    logic unused_wdata;

    assign hit_cfg      = (bus_addr == CFG_ADDR);
    assign hit_clr      = (bus_addr == CLR_ADDR);
    assign cfg_wr       = bus_we && hit_cfg;
    assign clr_wr       = bus_we && hit_clr;
    assign sel_bad      = &cfg_q.div_sel;
    assign unused_wdata = ^{bus_wdata[DATA_W-1:SEL_LSB+SEL_W], bus_wdata[2]};

    // Configuration storage: reset, wipe at pulse end, or bus load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wipe) begin
            cfg_q <= '0;
        end else if (cfg_wr) begin
            cfg_q.ena      <= bus_wdata[BIT_ENA];
            cfg_q.rst_mode <= bus_wdata[BIT_RSTM];
            cfg_q.irq_en   <= bus_wdata[BIT_IEN];
            cfg_q.div_sel  <= bus_wdata[SEL_LSB +: SEL_W];
        end
    end

    // Read mux: only the configuration address returns data.
    always_comb begin
        rdata = '0;
        if (hit_cfg) begin
            rdata[BIT_ENA]            = cfg_q.ena;
            rdata[BIT_RSTM]           = cfg_q.rst_mode;
            rdata[BIT_IEN]            = cfg_q.irq_en;
            rdata[SEL_LSB +: SEL_W]   = cfg_q.div_sel;
        end
    end

endmodule

// File: rtl/wdog_prescaler.sv
// Selectable power-of-two prescaler.
// It emits a one-cycle tick every 2^div_exp(sel) clocks while run is high.
// The count is held at zero while run is low and cleared by restart, and
// restart also suppresses a tick in its own cycle. Terminal detection uses a
// low-bit all-ones match for each select value instead of a full comparator.
module wdog_prescaler
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);

    logic [PRE_W-1:0] pre_q;
    logic [N_SEL-1:0] at_top;

    // One terminal-count detector per select value.
    for (genvar g = 0; g < N_SEL; g++) begin : g_top
        localparam int unsigned EXP = div_exp(3'(g));
        assign at_top[g] = &pre_q[EXP-1:0];
    end

    assign tick = run && !restart && at_top[div_sel];

    // Divider count: cleared when idle, on restart and on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run || restart || tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdog_counter.sv
// Watchdog up-counter.
// Held at PRELOAD while run is low. A clear sets it to zero and wins over a
// tick in the same cycle. wrap flags the tick that takes all-ones to zero.
module wdog_counter #(
    parameter int unsigned      CNT_W   = 16,
    parameter logic [CNT_W-1:0] PRELOAD = 16'hFFE0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    input  logic tick,
    output logic wrap
);

    logic [CNT_W-1:0] cnt_q;

    assign wrap = run && tick && !clear && (&cnt_q);

    // Count update: preload when idle, clear first, then advance on tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= PRELOAD;
        end else if (!run) begin
            cnt_q <= PRELOAD;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdog_pulse.sv
// Fixed-length pulse generator.
// fire starts a pulse of LEN cycles in the next cycle. A fire that arrives
// while a pulse is running is ignored. done is high in the last cycle of the
// pulse.
module wdog_pulse #(
    parameter int unsigned LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic active,
    output logic done
);

    localparam int unsigned LW = (LEN > 1) ? $clog2(LEN) : 1;

    logic [LW-1:0] left_q;
    logic          act_q;

    assign active = act_q;
    assign done   = act_q && (left_q == '0);

    // Pulse state: start on fire, count down, drop after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            left_q <= '0;
        end else if (!act_q) begin
            if (fire) begin
                act_q  <= 1'b1;
                left_q <= LW'(LEN - 1);
            end
        end else if (left_q == '0) begin
            act_q <= 1'b0;
        end else begin
            left_q <= left_q - 1'b1;
        end
    end

endmodule

// File: rtl/wdog_timer.sv
// Watchdog timer top.
// Connects the register decode, the prescaler, the counter and the reset
// pulse generator. A wrap in reset mode fires the pulse; otherwise, with
// the interrupt enabled, it gives a registered one-cycle interrupt.
// Assumes one bus access per cycle and a single clock domain.
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned RST_CYCLES = 16,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 32'h8000_0270,
    parameter logic [ADDR_W-1:0] CLR_ADDR = 32'h8000_0274,
    parameter logic [CNT_W-1:0]  PRELOAD  = 16'hFFE0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              chip_rst_o,
    output logic              irq_o,
    output logic              sel_bad_o
);

    wdog_cfg_t cfg_q;
    logic      cfg_wr;
    logic      clr_wr;
    logic      tick;
    logic      wrap;
    logic      wipe;
    logic      fire;
    logic      irq_q;

    wdog_regs #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CFG_ADDR (CFG_ADDR),
        .CLR_ADDR (CLR_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .wipe      (wipe),
        .cfg_q     (cfg_q),
        .cfg_wr    (cfg_wr),
        .clr_wr    (clr_wr),
        .rdata     (bus_rdata),
        .sel_bad   (sel_bad_o)
    );

    wdog_prescaler u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (cfg_q.ena),
        .restart (cfg_wr),
        .div_sel (cfg_q.div_sel),
        .tick    (tick)
    );

    wdog_counter #(
        .CNT_W   (CNT_W),
        .PRELOAD (PRELOAD)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (cfg_q.ena),
        .clear (clr_wr),
        .tick  (tick),
        .wrap  (wrap)
    );

    assign fire = wrap && cfg_q.rst_mode;

    wdog_pulse #(
        .LEN (RST_CYCLES)
    ) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (fire),
        .active (chip_rst_o),
        .done   (wipe)
    );

    // Interrupt flag: one cycle after a wrap in continue mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= wrap && !cfg_q.rst_mode && cfg_q.irq_en;
        end
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/wdog_timer_chk.sv
// Assertion checker for wdog_timer, attached with bind below.
// Watches the ports and the strobes that pass between the submodules.
module wdog_timer_chk
    import wdog_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned RST_CYCLES = 16,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 32'h8000_0270
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              chip_rst_o,
    input logic              irq_o,
    input logic              sel_bad_o,
    input wdog_cfg_t         cfg_q,
    input logic              cfg_wr,
    input logic              clr_wr,
    input logic              tick,
    input logic              wrap
);

    localparam int unsigned RLW = $clog2(RST_CYCLES) + 1;

    logic [RLW-1:0] run_len;

    // Run length of the current reset pulse, counted in prior high cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_len <= '0;
        else if (chip_rst_o)
            run_len <= run_len + 1'b1;
        else
            run_len <= '0;
    end

    AST_RDATA_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (bus_rdata[DATA_W-1:7] == '0) && !bus_rdata[2]); // R1
    AST_SEL7_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (bus_addr == CFG_ADDR) |-> (sel_bad_o == (&bus_rdata[6:4]))); // R2
    AST_IDLE_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n) !cfg_q.ena |=> !wrap); // R3
    AST_CLEAR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n) clr_wr |=> !wrap); // R4
    AST_RST_LEN_MAX: assert property (@(posedge clk) disable iff (!rst_n) chip_rst_o |-> (run_len < RLW'(RST_CYCLES))); // R5
    AST_RST_LEN_FULL: assert property (@(posedge clk) disable iff (!rst_n) $fell(chip_rst_o) |-> ($past(run_len) == RLW'(RST_CYCLES - 1))); // R5
    AST_CFG_WIPED: assert property (@(posedge clk) disable iff (!rst_n) $fell(chip_rst_o) |-> (cfg_q == '0)); // R6
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) irq_o |=> !irq_o); // R7
    AST_IRQ_MODE: assert property (@(posedge clk) disable iff (!rst_n) irq_o |-> ($past(!cfg_q.rst_mode && cfg_q.irq_en) && !chip_rst_o)); // R7
    AST_NO_RST_IRQ_MODE: assert property (@(posedge clk) disable iff (!rst_n) (wrap && !cfg_q.rst_mode) |=> !$rose(chip_rst_o)); // R7
    AST_NO_TICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n) cfg_wr |=> !tick); // R8

endmodule

bind wdog_timer wdog_timer_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .RST_CYCLES (RST_CYCLES),
    .CFG_ADDR   (CFG_ADDR)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .chip_rst_o (chip_rst_o),
    .irq_o      (irq_o),
    .sel_bad_o  (sel_bad_o),
    .cfg_q      (cfg_q),
    .cfg_wr     (cfg_wr),
    .clr_wr     (clr_wr),
    .tick       (tick),
    .wrap       (wrap)
);

// File: tb/wdog_timer_tb_top.sv
// Testbench for wdog_timer.
// A behavioural model of the watchdog is updated at every rising edge and
// compared with the outputs at every falling edge. Directed checks cover
// the timing of each scenario. Inputs change 1 ns after the rising edge.
module wdog_timer_tb_top;

    localparam logic [31:0] CFG_A = 32'h8000_0270;
    localparam logic [31:0] CLR_A = 32'h8000_0274;
    localparam logic [31:0] OTH_A = 32'h8000_0278;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = CFG_A;
    logic [15:0] wdata = '0;
    logic        we = 1'b0;
    wire  [15:0] rdata;
    wire         chip_rst;
    wire         irq;
    wire         sel_bad;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit cmp_on = 1'b0;
    int irq_seen = 0;
    int rst_hi = 0;

    // Model state
    logic [15:0] m_cfg = '0;
    int          m_cnt = 'hFFE0;
    int          m_pre = 0;
    int          m_left = 0;
    bit          m_irq = 1'b0;

    always #2 clk = ~clk;

    wdog_timer dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (addr),
        .bus_wdata  (wdata),
        .bus_we     (we),
        .bus_rdata  (rdata),
        .chip_rst_o (chip_rst),
        .irq_o      (irq),
        .sel_bad_o  (sel_bad)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model, one step per rising edge
    int  k, n;
    bit  en, cw, kw, tk, wr, wipe, fire;
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_cfg = '0; m_cnt = 'hFFE0; m_pre = 0; m_left = 0; m_irq = 1'b0;
        end else begin
            en   = m_cfg[0];
            cw   = we && (addr == CFG_A);
            kw   = we && (addr == CLR_A);
            k    = int'(m_cfg[6:4]);
            n    = (k < 5) ? (1 << (k + 1)) : ((k == 5) ? 1024 : 4096);
            tk   = en && !cw && (m_pre == n - 1);
            wr   = tk && !kw && (m_cnt == 65535);
            wipe = (m_left == 1);
            fire = wr && m_cfg[1];
            m_irq = wr && !m_cfg[1] && m_cfg[3];
            if (!en) m_cnt = 'hFFE0;
            else if (kw) m_cnt = 0;
            else if (tk) m_cnt = (m_cnt + 1) % 65536;
            if (!en || cw || tk) m_pre = 0; else m_pre++;
            if (m_left > 0) m_left--; else if (fire) m_left = 16;
            if (wipe) m_cfg = '0;
            else if (cw) m_cfg = wdata & 16'h007B;
        end
    end

    // Per-cycle comparison and event counters at the falling edge
    always @(negedge clk) begin
        if (cmp_on) begin
            check(chip_rst == (m_left > 0), "R5 chip_rst_o", int'(chip_rst), int'(m_left > 0));
            check(irq == m_irq, "R7 irq_o", int'(irq), int'(m_irq));
            check(rdata == ((addr == CFG_A) ? m_cfg : 16'h0), "R1 bus_rdata", int'(rdata),
                  int'((addr == CFG_A) ? m_cfg : 16'h0));
            check(sel_bad == (m_cfg[6:4] == 3'd7), "R2 sel_bad_o", int'(sel_bad), int'(m_cfg[6:4] == 3'd7));
            if (irq) irq_seen++;
            if (chip_rst) rst_hi++;
        end
    end

    // Watchdog on the bench itself
    always @(posedge clk) begin
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wait_clk(input int c);
        repeat (c) @(posedge clk);
        #1;
    endtask

    task automatic bus_write(input logic [31:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk); #1;
        we = 1'b0; addr = CFG_A; wdata = '0;
    endtask

    task automatic read_chk(input logic [31:0] a, input logic [15:0] exp, input string tag);
        addr = a;
        @(negedge clk);
        check(rdata == exp, tag, int'(rdata), int'(exp));
        @(posedge clk); #1;
        addr = CFG_A;
    endtask

    int base;
    int nd;

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        // R9: reset state
        read_chk(CFG_A, 16'h0000, "R9 cfg after reset");
        check(!chip_rst && !irq, "R9 outputs low after reset", int'({chip_rst, irq}), 0);

        // R1: undefined bits drop, fields read back, other addresses zero
        bus_write(CFG_A, 16'hFF84);
        read_chk(CFG_A, 16'h0000, "R1 reserved bits read zero");
        bus_write(CFG_A, 16'h007A);
        read_chk(CFG_A, 16'h007A, "R1 fields read back");
        check(sel_bad, "R2 select 7 flagged", int'(sel_bad), 1);
        read_chk(CLR_A, 16'h0000, "R1 clear register reads zero");
        read_chk(OTH_A, 16'h0000, "R1 unmapped address reads zero");
        bus_write(CFG_A, 16'h0000);

        // R3 and R8: enable at divide 2 without a clear, wrap after 32 ticks
        base = irq_seen;
        bus_write(CFG_A, 16'h0009);
        wait_clk(62);
        check(irq_seen == base, "R3 no irq before 32nd tick", irq_seen - base, 0);
        wait_clk(4);
        check(irq_seen == base + 1, "R3 irq after 32 ticks from preload", irq_seen - base, 1);

        // R2: wrap timing for select values 1..5
        for (int s = 1; s <= 5; s++) begin
            nd = (s < 5) ? (1 << (s + 1)) : 1024;
            bus_write(CFG_A, 16'h0000);
            base = irq_seen;
            bus_write(CFG_A, 16'((s << 4) | 9));
            wait_clk(32 * nd - 2);
            check(irq_seen == base, "R2 no early wrap", irq_seen - base, 0);
            wait_clk(4);
            check(irq_seen == base + 1, "R2 wrap at 32 divided periods", irq_seen - base, 1);
        end

        // R4: clears at varying phases, some meeting a tick
        bus_write(CFG_A, 16'h0000);
        base = irq_seen;
        bus_write(CFG_A, 16'h0009);
        bus_write(CLR_A, 16'h5A5A);
        for (int i = 0; i < 12; i++) begin
            wait_clk(8 + (i % 3));
            bus_write(CLR_A, 16'(i));
        end
        wait_clk(80);
        check(irq_seen == base, "R4 cleared counter never wraps", irq_seen - base, 0);

        // R4: clear exactly on a tick at the wrap point
        bus_write(CFG_A, 16'h0000);
        base = irq_seen;
        bus_write(CFG_A, 16'h0009);
        wait_clk(62);
        bus_write(CLR_A, 16'h0001);
        wait_clk(6);
        check(irq_seen == base, "R4 clear beats wrapping tick", irq_seen - base, 0);

        // R7: continue mode with interrupt disabled
        bus_write(CFG_A, 16'h0000);
        base = irq_seen;
        rst_hi = 0;
        bus_write(CFG_A, 16'h0001);
        wait_clk(90);
        check(irq_seen == base, "R7 no irq when disabled", irq_seen - base, 0);
        check(rst_hi == 0, "R7 no reset in continue mode", rst_hi, 0);

        // R5 and R6: reset mode
        bus_write(CFG_A, 16'h0000);
        base = irq_seen;
        rst_hi = 0;
        bus_write(CFG_A, 16'h000B);
        wait_clk(100);
        check(rst_hi == 16, "R5 reset pulse length", rst_hi, 16);
        check(irq_seen == base, "R5 no irq in reset mode", irq_seen - base, 0);
        read_chk(CFG_A, 16'h0000, "R6 config wiped after pulse");

        // R8: rewrites restart the prescaler and delay the wrap
        base = irq_seen;
        bus_write(CFG_A, 16'h0029);
        for (int i = 0; i < 4; i++) begin
            wait_clk(58);
            bus_write(CFG_A, 16'h0029);
        end
        wait_clk(30);
        check(irq_seen == base, "R8 wrap delayed by restarts", irq_seen - base, 0);
        wait_clk(4);
        check(irq_seen == base + 1, "R8 wrap after restarted ticks", irq_seen - base, 1);

        // R2: undefined select runs as the slowest divide
        bus_write(CFG_A, 16'h0000);
        bus_write(CFG_A, 16'h0079);
        wait_clk(300);
        check(sel_bad, "R2 flag while select is 7", int'(sel_bad), 1);

        // R9: reset during operation
        @(posedge clk); #1;
        rst_n = 1'b0;
        cmp_on = 1'b0;
        wait_clk(2);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        read_chk(CFG_A, 16'h0000, "R9 cfg cleared by reset");
        check(!chip_rst && !irq && !sel_bad, "R9 outputs low after reset",
              int'({chip_rst, irq, sel_bad}), 0);

        wait_clk(4);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule